// File: doc/BRIEF.md
# First-Fit Contiguous Page Allocator

This block manages a region of 128 pages of 16 words each. It keeps one occupancy bit per page. The first few pages are held back for configuration data, and those pages are marked used from reset. A client sends either an allocate request or a free request. An allocate request carries a size code and receives the lowest start page whose whole span is free, or a failure. A free request carries a start page and a size code and gives that span back to the pool.

An allocate request runs as a first-fit search. It tests one candidate start page per clock, starting at page 0 and stepping up by one page each cycle. The start page does not have to be aligned to the span size. The block reports busy for the whole of a request and signals the end with a single-cycle done pulse that carries the outcome. A request presented while the block is busy is ignored.

Top module: `pga_alloc`

## Requirements
- R1: After a synchronous reset, `busy` and `rsp_done` are low, and pages 0 to 3 are used, so the first one-page allocation returns page 4.
- R2: Size codes 0, 1, 2 and 3 request spans of 1, 2, 4 and 8 consecutive pages.
- R3: Pages 0 to 3 are never allocated and never freed. A free request whose start page is below 4 ends with `rsp_ok` low, and those pages stay used.
- R4: An allocate request returns the lowest start page whose span holds no used page. The block tests candidates 0, 1, 2 and so on, one per cycle. When a request is accepted at clock edge k and succeeds at page p, `rsp_done` is high in the cycle after edge k+1+p.
- R5: If no start page fits before the start page plus the span would exceed 128, the request ends with `rsp_ok` low after 130 minus span search cycles, and the occupancy is unchanged.
- R6: A successful allocation marks every page of the span used and reports the start page on `rsp_page` with `rsp_ok` high.
- R7: A free request is answered one cycle after acceptance. When it is valid, it clears every page of the span and reports `rsp_ok` high.
- R8: A free request whose span contains any page that is already free reports `rsp_ok` low and leaves every page unchanged.
- R9: A free request whose start page plus span exceeds 128 reports `rsp_ok` low and leaves every page unchanged.
- R10: A request is taken only when `req_valid` is high and `busy` is low. `req_op` 0 means allocate and 1 means free. Requests presented while busy are ignored. `rsp_done` lasts exactly one cycle, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 1 | 0 allocate, 1 free |
| req_size | input | 2 | Span code: span is 1 shifted left by the code |
| req_page | input | 7 | Start page for a free request |
| busy | output | 1 | A request is in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_ok | output | 1 | Outcome of the last request, valid with `rsp_done` |
| rsp_page | output | 7 | Start page of a successful allocation |

## Verification
The assertions check the following on every cycle:
- The done pulse is a single cycle, and `busy` is low in that cycle.
- The search candidate advances by exactly one page per step.
- A free request finishes in one step.
- The reserved pages stay set.
- A span is marked used only when it is wholly free.
- A span is cleared only when it is wholly used.

The bench scenarios show what no single-cycle property can capture:
- The first-fit order after a mix of frees and allocations.
- Failure once the region is full.
- Error frees that leave the map untouched, which later allocations expose.
- Requests held during a search being dropped.

// File: rtl/pga_pkg.sv
package pga_pkg;
  typedef enum logic {
    OP_ALLOC = 1'b0,
    OP_FREE  = 1'b1
  } pga_op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_FREE   = 2'd2
  } pga_state_e;
endpackage

// File: rtl/pga_span_mask.sv
module pga_span_mask #(
  parameter int SIZE_W = 2
) (
  input  logic [SIZE_W-1:0]                        size_code,
  output logic [(1 << ((1 << SIZE_W) - 1))-1:0]    span_mask,
  output logic [$clog2(1 << ((1 << SIZE_W) - 1)):0] span_len
);
  localparam int MAX_SPAN = 1 << ((1 << SIZE_W) - 1);
  localparam int SPAN_W   = $clog2(MAX_SPAN) + 1;

  assign span_len = SPAN_W'(1) << size_code;

  for (genvar i = 0; i < MAX_SPAN; i++) begin : g_bit
    assign span_mask[i] = (SPAN_W'(i) < span_len);
  end
endmodule

// File: rtl/pga_bitmap.sv
module pga_bitmap #(
  parameter int NUM_PAGES  = 128,
  parameter int RSVD_PAGES = 4,
  parameter int MAX_SPAN   = 8,
  parameter int PAGE_W     = $clog2(NUM_PAGES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PAGE_W-1:0]   win_base,
  input  logic [MAX_SPAN-1:0] win_mask,
  input  logic                set_en,
  input  logic                clr_en,
  output logic                win_busy,
  output logic                win_full
);
  localparam int EXT_W = NUM_PAGES + MAX_SPAN;
  localparam logic [NUM_PAGES-1:0] RSVD_MASK =
    {NUM_PAGES{1'b1}} >> (NUM_PAGES - RSVD_PAGES);

  logic [NUM_PAGES-1:0] map_q;
  logic [EXT_W-1:0]     ext_map;
  logic [EXT_W-1:0]     ext_shift;
  logic [EXT_W-1:0]     upd_wide;
  logic [MAX_SPAN-1:0]  win_bits;
  logic [NUM_PAGES-1:0] upd_mask;

  always_comb begin
    ext_map   = {{MAX_SPAN{1'b0}}, map_q};
    ext_shift = ext_map >> win_base;
    win_bits  = ext_shift[MAX_SPAN-1:0] & win_mask;
    win_busy  = |win_bits;
    win_full  = (win_bits == win_mask);
    upd_wide  = {{NUM_PAGES{1'b0}}, win_mask} << win_base;
    upd_mask  = upd_wide[NUM_PAGES-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q <= RSVD_MASK;
    end else if (set_en) begin
      map_q <= map_q | upd_mask;
    end else if (clr_en) begin
      map_q <= map_q & ~upd_mask;
    end
  end

  AST_RSVD_KEPT: assert property (@(posedge clk) disable iff (rst)
    (map_q & RSVD_MASK) == RSVD_MASK); // R3
  AST_SET_INTO_FREE: assert property (@(posedge clk) disable iff (rst)
    set_en |-> !win_busy); // R6
  AST_CLR_ONLY_USED: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> win_full); // R8
  AST_NO_SET_AND_CLR: assert property (@(posedge clk) disable iff (rst)
    !(set_en && clr_en)); // R10
endmodule

// File: rtl/pga_ctrl.sv
module pga_ctrl
  import pga_pkg::*;
#(
  parameter int NUM_PAGES  = 128,
  parameter int RSVD_PAGES = 4,
  parameter int SIZE_W     = 2,
  parameter int PAGE_W     = $clog2(NUM_PAGES),
  parameter int SPAN_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  pga_op_e           req_op,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [SPAN_W-1:0] span_len,
  input  logic              win_busy,
  input  logic              win_full,
  output logic [SIZE_W-1:0] size_q,
  output logic [PAGE_W-1:0] win_base,
  output logic              set_en,
  output logic              clr_en,
  output logic              busy,
  output logic              rsp_done,
  output logic              rsp_ok,
  output logic [PAGE_W-1:0] rsp_page
);
  localparam int CAND_W = PAGE_W + 1;
  localparam int END_W  = PAGE_W + 2;

  pga_state_e        st_q;
  pga_op_e           op_q;
  logic [CAND_W-1:0] cand_q;
  logic [END_W-1:0]  end_pos;
  logic              over;
  logic              rsvd_hit;
  logic              accept;
  logic              finish;
  logic              fin_ok;

  assign end_pos  = END_W'(cand_q) + END_W'(span_len);
  assign over     = end_pos > END_W'(NUM_PAGES);
  assign rsvd_hit = cand_q < CAND_W'(RSVD_PAGES);
  assign win_base = cand_q[PAGE_W-1:0];
  assign accept   = (st_q == ST_IDLE) && req_valid;

  always_comb begin
    finish = 1'b0;
    fin_ok = 1'b0;
    set_en = 1'b0;
    clr_en = 1'b0;
    unique case (st_q)
      ST_SEARCH: begin
        if (over) begin
          finish = 1'b1;
        end else if (!win_busy) begin
          finish = 1'b1;
          fin_ok = 1'b1;
          set_en = 1'b1;
        end
      end
      ST_FREE: begin
        finish = 1'b1;
        if (!over && !rsvd_hit && win_full) begin
          fin_ok = 1'b1;
          clr_en = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      op_q     <= OP_ALLOC;
      cand_q   <= '0;
      size_q   <= '0;
      busy     <= 1'b0;
      rsp_done <= 1'b0;
      rsp_ok   <= 1'b0;
      rsp_page <= '0;
    end else begin
      rsp_done <= finish;
      if (accept) begin
        op_q   <= req_op;
        size_q <= req_size;
        busy   <= 1'b1;
        if (req_op == OP_ALLOC) begin
          st_q   <= ST_SEARCH;
          cand_q <= '0;
        end else begin
          st_q   <= ST_FREE;
          cand_q <= {1'b0, req_page};
        end
      end else if (finish) begin
        st_q     <= ST_IDLE;
        busy     <= 1'b0;
        rsp_ok   <= fin_ok;
        rsp_page <= cand_q[PAGE_W-1:0];
      end else if (st_q == ST_SEARCH) begin
        cand_q <= cand_q + CAND_W'(1);
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> !busy); // R10
  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SEARCH && !finish) |=> (cand_q == $past(cand_q) + CAND_W'(1))); // R4
  AST_FREE_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FREE) |=> rsp_done); // R7
  AST_ALLOC_ABOVE_RSVD: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && rsp_ok && op_q == OP_ALLOC) |-> (rsp_page >= PAGE_W'(RSVD_PAGES))); // R3
endmodule

// File: rtl/pga_alloc.sv
module pga_alloc
  import pga_pkg::*;
#(
  parameter int NUM_PAGES  = 128,
  parameter int RSVD_PAGES = 4,
  parameter int SIZE_W     = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic                         req_op,
  input  logic [SIZE_W-1:0]            req_size,
  input  logic [$clog2(NUM_PAGES)-1:0] req_page,
  output logic                         busy,
  output logic                         rsp_done,
  output logic                         rsp_ok,
  output logic [$clog2(NUM_PAGES)-1:0] rsp_page
);
  localparam int PAGE_W   = $clog2(NUM_PAGES);
  localparam int MAX_SPAN = 1 << ((1 << SIZE_W) - 1);
  localparam int SPAN_W   = $clog2(MAX_SPAN) + 1;

  logic [SIZE_W-1:0]   size_q;
  logic [MAX_SPAN-1:0] span_mask;
  logic [SPAN_W-1:0]   span_len;
  logic [PAGE_W-1:0]   win_base;
  logic                set_en;
  logic                clr_en;
  logic                win_busy;
  logic                win_full;
  pga_op_e             op_in;

  assign op_in = pga_op_e'(req_op);

  pga_span_mask #(.SIZE_W(SIZE_W)) u_mask (
    .size_code (size_q),
    .span_mask (span_mask),
    .span_len  (span_len)
  );

  pga_bitmap #(
    .NUM_PAGES  (NUM_PAGES),
    .RSVD_PAGES (RSVD_PAGES),
    .MAX_SPAN   (MAX_SPAN),
    .PAGE_W     (PAGE_W)
  ) u_map (
    .clk      (clk),
    .rst      (rst),
    .win_base (win_base),
    .win_mask (span_mask),
    .set_en   (set_en),
    .clr_en   (clr_en),
    .win_busy (win_busy),
    .win_full (win_full)
  );

  pga_ctrl #(
    .NUM_PAGES  (NUM_PAGES),
    .RSVD_PAGES (RSVD_PAGES),
    .SIZE_W     (SIZE_W),
    .PAGE_W     (PAGE_W),
    .SPAN_W     (SPAN_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (op_in),
    .req_size  (req_size),
    .req_page  (req_page),
    .span_len  (span_len),
    .win_busy  (win_busy),
    .win_full  (win_full),
    .size_q    (size_q),
    .win_base  (win_base),
    .set_en    (set_en),
    .clr_en    (clr_en),
    .busy      (busy),
    .rsp_done  (rsp_done),
    .rsp_ok    (rsp_ok),
    .rsp_page  (rsp_page)
  );
endmodule

// File: tb/pga_alloc_tb_top.sv
module pga_alloc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 128;
  localparam int RSV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_op = 1'b0;
  logic [1:0] req_size = 2'd0;
  logic [6:0] req_page = 7'd0;
  logic       busy, rsp_done, rsp_ok;
  logic [6:0] rsp_page;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pga_alloc dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_size(req_size), .req_page(req_page), .busy(busy),
    .rsp_done(rsp_done), .rsp_ok(rsp_ok), .rsp_page(rsp_page)
  );

  // Behavioural reference: one bit per page, a countdown to completion.
  bit    mdl_map [NP];
  int    cnt = 0;
  bit    busy_e = 0, done_e = 0, ok_e = 0, alloc_e = 0;
  int    page_e = 0, pend_start = 0, pend_span = 0;
  bit    pend_set = 0, pend_clr = 0;
  string tag_e = "R1";

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NP; i++) mdl_map[i] = (i < RSV);
      cnt = 0; busy_e = 0; done_e = 0; ok_e = 0;
    end else begin
      done_e = 0;
      if (cnt > 0) begin
        cnt = cnt - 1;
        if (cnt == 0) begin
          done_e = 1; busy_e = 0;
          for (int i = 0; i < pend_span; i++) begin
            if (pend_set) mdl_map[pend_start+i] = 1;
            if (pend_clr) mdl_map[pend_start+i] = 0;
          end
        end
      end else if (req_valid) begin
        int sp;
        sp = 1 << req_size;
        busy_e = 1; pend_set = 0; pend_clr = 0; pend_span = sp;
        if (req_op == 1'b0) begin
          int found;
          found = -1;
          alloc_e = 1;
          for (int s = 0; s + sp <= NP; s++) begin
            bit fr;
            fr = 1;
            for (int j = 0; j < sp; j++) if (mdl_map[s+j]) fr = 0;
            if (fr && found < 0) found = s;
          end
          if (found >= 0) begin
            cnt = found + 1; ok_e = 1; page_e = found;
            pend_set = 1; pend_start = found; tag_e = "R6";
          end else begin
            cnt = 130 - sp; ok_e = 0; tag_e = "R5";
          end
        end else begin
          int pg;
          pg = int'(req_page);
          alloc_e = 0; cnt = 1; pend_start = pg;
          if (pg + sp > NP) begin ok_e = 0; tag_e = "R9"; end
          else if (pg < RSV) begin ok_e = 0; tag_e = "R3"; end
          else begin
            bit allused;
            allused = 1;
            for (int j = 0; j < sp; j++) if (!mdl_map[pg+j]) allused = 0;
            ok_e = allused; pend_clr = allused;
            tag_e = allused ? "R7" : "R8";
          end
        end
      end
    end
  end

  // Per-cycle comparison, sampled on the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (busy !== busy_e) begin
        errors++;
        $display("FAIL R10 busy act=%0b exp=%0b t=%0t", busy, busy_e, $time);
      end
      checks++;
      if (rsp_done !== done_e) begin
        errors++;
        $display("FAIL %s done timing (R4) act=%0b exp=%0b t=%0t", tag_e, rsp_done, done_e, $time);
      end
      if (done_e) begin
        checks++;
        if (rsp_ok !== ok_e) begin
          errors++;
          $display("FAIL %s ok act=%0b exp=%0b", tag_e, rsp_ok, ok_e);
        end
        if (alloc_e && ok_e) begin
          checks++;
          if (int'(rsp_page) != page_e) begin
            errors++;
            $display("FAIL R4 first-fit page act=%0d exp=%0d", rsp_page, page_e);
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R10 watchdog act=hung exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_req(input bit op, input int sz, input int pg,
                        output bit ok, output int rp);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_size = 2'(sz); req_page = 7'(pg);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done) @(negedge clk);
    ok = rsp_ok; rp = int'(rsp_page);
  endtask

  initial begin
    bit ok;
    int rp, big;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_val("R1 busy after reset", int'(busy), 0);
    check_val("R1 done after reset", int'(rsp_done), 0);

    do_req(0, 0, 0, ok, rp); check_val("R1 first page", rp, 4);
    do_req(0, 1, 0, ok, rp); check_val("R2 two-page span", rp, 5);
    do_req(0, 2, 0, ok, rp); check_val("R2 four-page span", rp, 7);
    do_req(0, 3, 0, ok, rp); check_val("R2 eight-page span", rp, 11);

    do_req(1, 1, 5, ok, rp); check_val("R7 free ok", int'(ok), 1);
    do_req(0, 0, 0, ok, rp); check_val("R4 lowest hole", rp, 5);
    do_req(0, 1, 0, ok, rp); check_val("R4 skip short hole", rp, 19);

    do_req(1, 0, 6, ok, rp); check_val("R8 already free", int'(ok), 0);
    do_req(0, 0, 0, ok, rp); check_val("R8 map unchanged", rp, 6);
    do_req(1, 0, 2, ok, rp); check_val("R3 reserved free", int'(ok), 0);
    do_req(1, 2, 126, ok, rp); check_val("R9 past end", int'(ok), 0);

    // Requests held high during a long search must be dropped (R10).
    @(negedge clk);
    req_valid = 1'b1; req_op = 1'b0; req_size = 2'd3;
    @(negedge clk);
    req_op = 1'b1; req_size = 2'd0; req_page = 7'd4;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done) @(negedge clk);
    big = int'(rsp_page);
    check_val("R10 search result", big, 21);
    do_req(1, 0, 4, ok, rp); check_val("R10 held free ignored", int'(ok), 1);

    // Fill the region until an allocation fails (R5).
    ok = 1;
    for (int i = 0; i < 20 && ok; i++) do_req(0, 3, 0, ok, rp);
    check_val("R5 region exhausted", int'(ok), 0);
    do_req(0, 0, 0, ok, rp); check_val("R5 map unchanged", rp, 4);

    do_req(1, 3, big, ok, rp); check_val("R7 free span", int'(ok), 1);
    do_req(1, 0, big + 2, ok, rp); check_val("R8 inside freed span", int'(ok), 0);
    do_req(0, 2, 0, ok, rp); check_val("R6 reuse freed span", rp, big);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule